// File: doc/BRIEF.md
# Bus-Programmed Supply Control Register

This block is a write-oriented two-wire serial slave that holds a single control byte for a power-management die. The byte turns on two linear regulators and two high-side switches and chooses their output voltages. A host addresses the block, sends one or more data bytes, and the last byte acknowledged sets the outputs. The host can also read the stored byte back.

SCL and SDA arrive as raw pins. A fast system clock oversamples them through synchronizer stages, so no bus clock ever clocks a flop. The block only answers while the chip-level enable input is high. While an overvoltage flag is raised, every enable output is held off. When the flag drops, the enables return to the stored values on their own.

The block drives SDA only through an active-high pull-down output. Clock stretching is not used.

Top module: `pwr_ctl_slave`

## Requirements
- R1: After reset, every enable and select output is 0 and the SDA pull-down is released.
- R2: A write addressed to 7-bit address 0001000 (first byte 0x10) is acknowledged on the address byte and on each data byte. The outputs are then driven from the byte as follows: bit7 enables regulator 2, bits 6:4 are the regulator 2 voltage code (passed through unchanged), bit3 enables regulator 1, bit2 selects the regulator 1 voltage, bit1 enables switch 2 and bit0 enables switch 1.
- R3: A byte sent after a start whose 7-bit address is not 0001000 gets no acknowledge, and the stored byte does not change.
- R4: A read (first byte 0x11) acknowledges the address and then returns the stored byte MSB first. Each byte the host acknowledges is followed by the same byte again, and a host non-acknowledge ends the read.
- R5: While the enable input is low, the block acknowledges nothing and the stored byte is cleared to 0x00.
- R6: While the overvoltage flag is high, all four enable outputs are 0 and the select outputs keep their stored values. When the flag falls, the enables return to the stored values without any bus traffic.
- R7: Several data bytes in one write are each acknowledged, and each one overwrites the stored byte.
- R8: A repeated start restarts address matching, whatever state the transfer was in.
- R9: The SDA pull-down changes only while synchronized SCL is low, except when the enable input forces it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Chip enable; the serial logic is active only while this is high |
| ovp_i | input | 1 | Overvoltage flag; forces all enables off |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| sda_pd_o | output | 1 | SDA pull-down; 1 pulls the line low |
| reg2_en_o | output | 1 | Regulator 2 enable |
| reg2_vsel_o | output | 3 | Regulator 2 voltage code |
| reg1_en_o | output | 1 | Regulator 1 enable |
| reg1_vsel_o | output | 1 | Regulator 1 voltage select |
| sw2_en_o | output | 1 | High-side switch 2 enable |
| sw1_en_o | output | 1 | High-side switch 1 enable |

## Verification
A data-byte write and an overvoltage event can land in the same cycle. The bench raises the overvoltage flag and then writes a new byte while the flag is still high. It checks that the selects take the new code at once while the enables stay at 0. After the flag drops, it checks that the enables come back from the byte written during the event and not from the older one. Disabling the chip in the middle of a transfer is checked in the same way: the stored byte must be cleared, and the next transfer must be read back as 0x00.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_AACK,
        LK_WDAT,
        LK_WACK,
        LK_RDAT,
        LK_RACK
    } link_st_t;

    typedef struct packed {
        link_st_t   st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ctrl;
        logic       pd;
        logic       rw;
        logic       mack;
        logic       scl_p;
        logic       sda_p;
    } link_t;
endpackage

// File: rtl/pwr_ctl_sync.sv
module pwr_ctl_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= IDLE_VAL;
                    else        chain_q[g] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= IDLE_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_ctl_link.sv
module pwr_ctl_link
    import pwr_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h08,
    parameter int         BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              pd_o,
    output logic [BYTE_W-1:0] ctrl_o
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    link_t q, d;
    logic  rise, fall, start_c, stop_c;

    always_comb begin
        rise    = scl_s & ~q.scl_p;
        fall    = ~scl_s & q.scl_p;
        start_c = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_c  = scl_s & q.scl_p & ~q.sda_p & sda_s;

        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;

        if (!en_i) begin
            d.st   = LK_IDLE;
            d.pd   = 1'b0;
            d.cnt  = '0;
            d.ctrl = '0;
        end else if (start_c) begin
            d.st  = LK_ADDR;
            d.cnt = '0;
            d.pd  = 1'b0;
        end else if (stop_c) begin
            d.st = LK_IDLE;
            d.pd = 1'b0;
        end else begin
            unique case (q.st)
                LK_IDLE: ;
                LK_ADDR: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == LAST_BIT) begin
                        if (q.sh[7:1] == DEV_ADDR) begin
                            d.st = LK_AACK;
                            d.rw = q.sh[0];
                            d.pd = 1'b1;
                        end else begin
                            d.st = LK_IDLE;
                        end
                    end
                end
                LK_AACK: begin
                    if (fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = LK_RDAT;
                            d.sh = q.ctrl;
                            d.pd = ~q.ctrl[7];
                        end else begin
                            d.st = LK_WDAT;
                            d.pd = 1'b0;
                        end
                    end
                end
                LK_WDAT: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == LAST_BIT) begin
                        d.ctrl = q.sh;
                        d.st   = LK_WACK;
                        d.pd   = 1'b1;
                    end
                end
                LK_WACK: begin
                    if (fall) begin
                        d.st  = LK_WDAT;
                        d.cnt = '0;
                        d.pd  = 1'b0;
                    end
                end
                LK_RDAT: begin
                    if (rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.st = LK_RACK;
                            d.pd = 1'b0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.pd = ~q.sh[6];
                        end
                    end
                end
                LK_RACK: begin
                    if (rise) begin
                        d.mack = ~sda_s;
                    end else if (fall) begin
                        if (q.mack) begin
                            d.st  = LK_RDAT;
                            d.cnt = '0;
                            d.sh  = q.ctrl;
                            d.pd  = ~q.ctrl[7];
                        end else begin
                            d.st = LK_IDLE;
                        end
                    end
                end
                default: d.st = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= LK_IDLE;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.ctrl  <= '0;
            q.pd    <= 1'b0;
            q.rw    <= 1'b0;
            q.mack  <= 1'b0;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pd_o   = q.pd;
    assign ctrl_o = q.ctrl;
endmodule

// File: rtl/pwr_ctl_outmap.sv
module pwr_ctl_outmap #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic              ovp_i,
    output logic              reg2_en_o,
    output logic [2:0]        reg2_vsel_o,
    output logic              reg1_en_o,
    output logic              reg1_vsel_o,
    output logic              sw2_en_o,
    output logic              sw1_en_o
);
    logic allow;

    always_comb begin
        allow       = ~ovp_i;
        reg2_en_o   = ctrl_i[7] & allow;
        reg2_vsel_o = ctrl_i[6:4];
        reg1_en_o   = ctrl_i[3] & allow;
        reg1_vsel_o = ctrl_i[2];
        sw2_en_o    = ctrl_i[1] & allow;
        sw1_en_o    = ctrl_i[0] & allow;
    end
endmodule

// File: rtl/pwr_ctl_slave.sv
module pwr_ctl_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en_i,
    input  logic       ovp_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pd_o,
    output logic       reg2_en_o,
    output logic [2:0] reg2_vsel_o,
    output logic       reg1_en_o,
    output logic       reg1_vsel_o,
    output logic       sw2_en_o,
    output logic       sw1_en_o
);
    localparam int BYTE_W = 8;

    logic              scl_s, sda_s;
    logic [BYTE_W-1:0] ctrl;

    pwr_ctl_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );
    pwr_ctl_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    pwr_ctl_link #(.DEV_ADDR(DEV_ADDR), .BYTE_W(BYTE_W)) u_link (
        .clk(clk), .rst_n(rst_n), .en_i(chip_en_i),
        .scl_s(scl_s), .sda_s(sda_s),
        .pd_o(sda_pd_o), .ctrl_o(ctrl)
    );

    pwr_ctl_outmap #(.BYTE_W(BYTE_W)) u_map (
        .ctrl_i(ctrl), .ovp_i(ovp_i),
        .reg2_en_o(reg2_en_o), .reg2_vsel_o(reg2_vsel_o),
        .reg1_en_o(reg1_en_o), .reg1_vsel_o(reg1_vsel_o),
        .sw2_en_o(sw2_en_o), .sw1_en_o(sw1_en_o)
    );
endmodule

// File: rtl/pwr_ctl_checker.sv
module pwr_ctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en_i,
    input logic       ovp_i,
    input logic       scl_s,
    input logic       sda_pd_o,
    input logic       reg2_en_o,
    input logic [2:0] reg2_vsel_o,
    input logic       reg1_en_o,
    input logic       reg1_vsel_o,
    input logic       sw2_en_o,
    input logic       sw1_en_o
);
    a_r6_ovp_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_i |-> !(reg2_en_o || reg1_en_o || sw2_en_o || sw1_en_o));

    a_r5_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_i |=> (!sda_pd_o && reg2_vsel_o == 3'd0 && !reg1_vsel_o
                        && !reg2_en_o && !reg1_en_o && !sw2_en_o && !sw1_en_o));

    a_r9_pd_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd_o) |-> $past(!scl_s));

    a_r9_pd_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pd_o) |-> ($past(!scl_s) || $past(!chip_en_i)));

    a_r2_sel_moves_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_i && $past(chip_en_i) && !$stable(reg2_vsel_o)) |-> $past(!scl_s));
endmodule

bind pwr_ctl_slave pwr_ctl_checker u_checker (
    .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en_i), .ovp_i(ovp_i),
    .scl_s(scl_s), .sda_pd_o(sda_pd_o),
    .reg2_en_o(reg2_en_o), .reg2_vsel_o(reg2_vsel_o),
    .reg1_en_o(reg1_en_o), .reg1_vsel_o(reg1_vsel_o),
    .sw2_en_o(sw2_en_o), .sw1_en_o(sw1_en_o)
);

// File: tb/pwr_ctl_slave_bench.sv
module pwr_ctl_slave_bench;
    localparam int HALF = 10; // system clocks per SCL half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0;
    logic       ovp = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pd;
    logic       r2_en, r1_en, r1_sel, s2_en, s1_en;
    logic [2:0] r2_sel;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pd;

    pwr_ctl_slave u_pwr_ctl_slave (
        .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en), .ovp_i(ovp),
        .scl_i(scl_m), .sda_i(sda_line), .sda_pd_o(sda_pd),
        .reg2_en_o(r2_en), .reg2_vsel_o(r2_sel),
        .reg1_en_o(r1_en), .reg1_vsel_o(r1_sel),
        .sw2_en_o(s2_en), .sw1_en_o(s1_en)
    );

    function automatic logic [7:0] outs_now();
        return {r2_en, r2_sel, r1_en, r1_sel, s2_en, s1_en};
    endfunction

    function automatic logic [7:0] outs_exp(logic [7:0] b, logic ov);
        logic [7:0] e;
        e = b;
        if (ov) begin
            e[7] = 1'b0; e[3] = 1'b0; e[1] = 1'b0; e[0] = 1'b0;
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(HALF);
            scl_m = 1'b1; wt(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF / 2);
        acked = ~sda_line;
        wt(HALF - HALF / 2);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(HALF);
            scl_m = 1'b1; wt(HALF / 2);
            b[i] = sda_line;
            wt(HALF - HALF / 2);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        scl_m = 1'b0; wt(HALF);
        sda_m = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] v, output bit a_ack, output bit d_ack);
        bus_start();
        put_byte(8'h10, a_ack);
        put_byte(v, d_ack);
        bus_stop();
        wt(4);
    endtask

    task automatic read_one(output bit a_ack, output logic [7:0] v);
        bus_start();
        put_byte(8'h11, a_ack);
        get_byte(1'b0, v);
        bus_stop();
        wt(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit         aa, da, ab;
        logic [7:0] rv, held;
        wt(5);
        // R1: reset state
        check(outs_now() == 8'h00, "R1 outputs", outs_now(), 0);
        check(sda_pd == 1'b0, "R1 pulldown", sda_pd, 0);
        rst_n = 1'b1; chip_en = 1'b1; wt(5);
        check(outs_now() == 8'h00, "R1 after release", outs_now(), 0);

        // R2/R4: sweep of values, write then read back
        for (int i = 0; i < 48; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 5) % 256);
            write_one(v, aa, da);
            check(aa, "R2 addr ack", aa, 1);
            check(da, "R2 data ack", da, 1);
            check(outs_now() == outs_exp(v, 1'b0), "R2 outputs", outs_now(), v);
            read_one(aa, rv);
            check(aa, "R4 read addr ack", aa, 1);
            check(rv == v, "R4 readback", rv, v);
        end
        // R2: every regulator 2 voltage code
        for (int c = 0; c < 8; c++) begin
            logic [7:0] v;
            v = {1'b1, 3'(c), 4'b0101};
            write_one(v, aa, da);
            check(r2_sel == 3'(c), "R2 vsel code", r2_sel, c);
        end

        // R4: continued read with host acks returns the byte again
        write_one(8'hA6, aa, da);
        bus_start();
        put_byte(8'h11, aa);
        get_byte(1'b1, rv);
        check(rv == 8'hA6, "R4 first read byte", rv, 8'hA6);
        get_byte(1'b0, rv);
        check(rv == 8'hA6, "R4 repeated read byte", rv, 8'hA6);
        bus_stop(); wt(4);

        // R3: every other address, write and read forms, ignored
        held = 8'hA6;
        for (int a = 0; a < 128; a++) begin
            if (a != 8) begin
                bus_start();
                put_byte({7'(a), 1'(a & 1)}, aa);
                check(!aa, "R3 foreign address nack", aa, 0);
                put_byte(8'h00, da);
                check(!da, "R3 foreign data nack", da, 0);
                bus_stop(); wt(4);
            end
        end
        check(outs_now() == outs_exp(held, 1'b0), "R3 register kept", outs_now(), held);

        // R7: three data bytes, each acked, last wins
        bus_start();
        put_byte(8'h10, aa);
        put_byte(8'h11, da); check(da, "R7 ack byte1", da, 1);
        put_byte(8'h22, da); check(da, "R7 ack byte2", da, 1);
        check(outs_now() == 8'h22, "R7 mid transfer", outs_now(), 8'h22);
        put_byte(8'hC9, da); check(da, "R7 ack byte3", da, 1);
        bus_stop(); wt(4);
        check(outs_now() == 8'hC9, "R7 last wins", outs_now(), 8'hC9);

        // R8: repeated start after foreign address, then after a write
        bus_start();
        put_byte(8'h40, aa); check(!aa, "R8 foreign nack", aa, 0);
        bus_start();
        put_byte(8'h10, aa); check(aa, "R8 restart match", aa, 1);
        put_byte(8'h3C, da);
        bus_start();
        put_byte(8'h11, aa); check(aa, "R8 restart to read", aa, 1);
        get_byte(1'b0, rv);
        check(rv == 8'h3C, "R8 read after restart", rv, 8'h3C);
        bus_stop(); wt(4);

        // R6: overvoltage forcing, write during the event, self recovery
        ovp = 1'b1; wt(2);
        check(outs_now() == outs_exp(8'h3C, 1'b1), "R6 forced off", outs_now(), outs_exp(8'h3C, 1'b1));
        write_one(8'hFB, aa, da);
        check(da, "R6 ack during ovp", da, 1);
        check(outs_now() == outs_exp(8'hFB, 1'b1), "R6 sel live in ovp", outs_now(), outs_exp(8'hFB, 1'b1));
        ovp = 1'b0; wt(2);
        check(outs_now() == 8'hFB, "R6 recovered", outs_now(), 8'hFB);

        // R5: enable low clears and ignores bus
        chip_en = 1'b0; wt(3);
        check(outs_now() == 8'h00, "R5 cleared", outs_now(), 0);
        bus_start();
        put_byte(8'h10, ab); check(!ab, "R5 no ack when disabled", ab, 0);
        put_byte(8'h77, da);
        bus_stop(); wt(4);
        check(outs_now() == 8'h00, "R5 write ignored", outs_now(), 0);
        chip_en = 1'b1; wt(3);
        read_one(aa, rv);
        check(rv == 8'h00, "R5 readback zero", rv, 0);
        // R5: disable in the middle of a write
        bus_start();
        put_byte(8'h10, aa);
        chip_en = 1'b0; wt(3);
        chip_en = 1'b1;
        put_byte(8'h5A, da);
        check(!da, "R5 aborted transfer nack", da, 0);
        bus_stop(); wt(4);
        check(outs_now() == 8'h00, "R5 abort kept clear", outs_now(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule